// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the fixed-point multiply-accumulate datapath of a DSP core. Each issued operation multiplies two 32-bit operands into an exact product. The product can be loaded into an 80-bit accumulator, added to it, or subtracted from it. A separate operation clears the accumulator. Per-operation controls choose the signedness of each operand independently. This makes signed, unsigned and mixed pairs available, so that wider products can be assembled from 32-bit pieces. A fractional control treats signed operands as 1.31 values.

The accumulator holds 16 guard bits above the 64-bit product range. Long sums can therefore grow without wrapping. A read port returns either the low 64 bits of the accumulator or a value clamped to the signed 64-bit range. An overflow flag is raised whenever the guard bits do not merely repeat the sign. The accumulator, the result and the flag are all registered. They reflect an operation one clock after it is issued, and an operation may be issued on every clock.

Top module: `fxmac_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `acc_q`, `result_q` and `ovf_q` become zero.
- R2: Opcode 2'b01 (load) with both operands signed places the exact integer product, sign-extended to 80 bits, in `acc_q` one cycle after issue.
- R3: When neither operand is signed, both operands are read as unsigned and the product is zero-extended.
- R4: With exactly one operand signed, the signed operand is read as two's complement and the other as unsigned. The product is exact and sign-extended.
- R5: With `frac_mode` high and both operands signed, the product is doubled (1.31 × 1.31 → 1.63). With `frac_mode` high and either operand unsigned, the product is not doubled.
- R6: Opcode 2'b10 adds the product to `acc_q`, modulo 2^80.
- R7: Opcode 2'b11 subtracts the product from `acc_q`, modulo 2^80.
- R8: Opcode 2'b00 sets `acc_q` to zero, whatever the operands are.
- R9: When `op_valid` is low, `acc_q` keeps its value. `result_q` still follows `rd_sat` one cycle later.
- R10: With `rd_sat` low, `result_q` equals bits 63:0 of the accumulator value it reports.
- R11: `ovf_q` is high exactly when accumulator bits 79:63 are not all equal. With `rd_sat` high and `ovf_q` set, `result_q` is 64'h7FFF_FFFF_FFFF_FFFF for a positive accumulator and 64'h8000_0000_0000_0000 for a negative one.
- R12: Operations issued on consecutive cycles are each applied, one per cycle, with a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 2 | 00 clear, 01 load, 10 add, 11 subtract |
| a_signed | input | 1 | Operand A is two's complement |
| b_signed | input | 1 | Operand B is two's complement |
| frac_mode | input | 1 | Fractional interpretation of signed operands |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| rd_sat | input | 1 | Saturated read-out select |
| acc_q | output | 80 | Accumulator value |
| result_q | output | 64 | Read-out of the accumulator, full low half or clamped |
| ovf_q | output | 1 | Guard bits hold more than a sign extension |

## Verification
The bench targets four kinds of corner case.

The first is the largest unsigned product, 0xFFFFFFFF squared. This value lands in bit 63. A design that sign-extends the product on an unsigned pair would record it as a negative number.

The second is mixed-signedness pairs with all-ones and minimum operands. A design that treats both operands alike gives a product that is off by a multiple of 2^32.

The third is the fractional square of −1.0. It needs the guard bits to hold +1.0, and a saturating read must clamp it. A design that doubles unsigned products or drops the shifted-out bit gives the wrong magnitude, or fails to flag overflow.

The fourth is back-to-back subtracts that drive the accumulator far negative, together with idle cycles. These would catch a flag computed from the wrong bits, a clamp with the wrong polarity, or an accumulator that drifts while no operation is issued.

// File: rtl/fxmac_pkg.sv
package fxmac_pkg;
  typedef enum logic [1:0] {
    MAC_CLR  = 2'b00,
    MAC_LOAD = 2'b01,
    MAC_ADD  = 2'b10,
    MAC_SUB  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/fxmac_mult.sv
// Exact product of two operands with per-operand signedness, optionally
// doubled for signed fractional data, extended to the accumulator width.
module fxmac_mult #(
  parameter int OP_W    = 32,
  parameter int ACC_W   = 80,
  parameter bit FRAC_EN = 1'b1
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  logic             a_sgn,
  input  logic             b_sgn,
  input  logic             frac,
  output logic [ACC_W-1:0] prod_ext
);
  localparam int FULL_W = 2*OP_W + 2;
  localparam int EXT_W  = ACC_W - FULL_W;

  logic signed [OP_W:0]     ax, bx;
  logic signed [FULL_W-1:0] ax_w, bx_w, full, shaped;

  // one extra top bit carries the sign or a zero, so every pair is signed
  assign ax   = {a_sgn & a[OP_W-1], a};
  assign bx   = {b_sgn & b[OP_W-1], b};
  assign ax_w = {{(OP_W+1){ax[OP_W]}}, ax};
  assign bx_w = {{(OP_W+1){bx[OP_W]}}, bx};
  assign full = ax_w * bx_w;

  generate
    if (FRAC_EN) begin : g_frac
      assign shaped = (frac & a_sgn & b_sgn) ? {full[FULL_W-2:0], 1'b0} : full;
    end else begin : g_int
      logic unused_frac;
      assign unused_frac = frac;
      assign shaped      = full;
    end
  endgenerate

  assign prod_ext = {{EXT_W{shaped[FULL_W-1]}}, shaped};
endmodule

// File: rtl/fxmac_acc.sv
// Accumulator register with clear, load, add and subtract.
module fxmac_acc
  import fxmac_pkg::*;
#(
  parameter int ACC_W = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  mac_op_e          op,
  input  logic [ACC_W-1:0] prod_ext,
  output logic [ACC_W-1:0] acc_nxt,
  output logic [ACC_W-1:0] acc_q
);
  always_comb begin
    acc_nxt = acc_q;
    if (valid) begin
      unique case (op)
        MAC_CLR:  acc_nxt = '0;
        MAC_LOAD: acc_nxt = prod_ext;
        MAC_ADD:  acc_nxt = acc_q + prod_ext;
        MAC_SUB:  acc_nxt = acc_q - prod_ext;
        default:  acc_nxt = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_nxt;
  end
endmodule

// File: rtl/fxmac_readout.sv
// Read-out: low half, or clamp to the signed product range with a flag.
module fxmac_readout #(
  parameter int PROD_W = 64,
  parameter int ACC_W  = 80
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic              sat,
  output logic [PROD_W-1:0] res,
  output logic              ovf
);
  localparam int TOP_W = ACC_W - PROD_W + 1;

  logic [TOP_W-1:0]  top;
  logic [PROD_W-1:0] pos_lim, neg_lim;

  assign top     = acc[ACC_W-1:PROD_W-1];
  assign ovf     = ~((&top) | ~(|top));
  assign pos_lim = {1'b0, {(PROD_W-1){1'b1}}};
  assign neg_lim = {1'b1, {(PROD_W-1){1'b0}}};

  always_comb begin
    res = acc[PROD_W-1:0];
    if (sat && ovf) res = acc[ACC_W-1] ? neg_lim : pos_lim;
  end
endmodule

// File: rtl/fxmac_unit.sv
module fxmac_unit
  import fxmac_pkg::*;
#(
  parameter int  OP_W    = 32,
  parameter int  GUARD_W = 16,
  parameter bit  FRAC_EN = 1'b1,
  localparam int PROD_W  = 2*OP_W,
  localparam int ACC_W   = PROD_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic              a_signed,
  input  logic              b_signed,
  input  logic              frac_mode,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic              rd_sat,
  output logic [ACC_W-1:0]  acc_q,
  output logic [PROD_W-1:0] result_q,
  output logic              ovf_q
);
  logic [ACC_W-1:0]  prod_ext, acc_nxt;
  logic [PROD_W-1:0] res_d;
  logic              ovf_d;

  fxmac_mult #(.OP_W(OP_W), .ACC_W(ACC_W), .FRAC_EN(FRAC_EN)) u_mult (
    .a(op_a), .b(op_b), .a_sgn(a_signed), .b_sgn(b_signed),
    .frac(frac_mode), .prod_ext(prod_ext)
  );

  fxmac_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .valid(op_valid), .op(mac_op_e'(op_code)),
    .prod_ext(prod_ext), .acc_nxt(acc_nxt), .acc_q(acc_q)
  );

  fxmac_readout #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_rd (
    .acc(acc_nxt), .sat(rd_sat), .res(res_d), .ovf(ovf_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      result_q <= res_d;
      ovf_q    <= ovf_d;
    end
  end
endmodule

// File: rtl/fxmac_chk.sv
module fxmac_chk #(
  parameter int OP_W    = 32,
  parameter int GUARD_W = 16,
  localparam int PROD_W = 2*OP_W,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [1:0]        op_code,
  input logic              rd_sat,
  input logic [ACC_W-1:0]  acc_q,
  input logic [PROD_W-1:0] result_q,
  input logic              ovf_q
);
  localparam logic [PROD_W-1:0] POS_LIM = {1'b0, {(PROD_W-1){1'b1}}};
  localparam logic [PROD_W-1:0] NEG_LIM = {1'b1, {(PROD_W-1){1'b0}}};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && result_q == '0 && !ovf_q));

  // R8
  clear_op_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'b00) |=> acc_q == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(acc_q));

  // R10
  full_read_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_sat |=> result_q == acc_q[PROD_W-1:0]);

  // R11
  sat_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    rd_sat |=> (!ovf_q || result_q == POS_LIM || result_q == NEG_LIM));
endmodule

bind fxmac_unit fxmac_chk #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_fxmac_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .rd_sat(rd_sat), .acc_q(acc_q), .result_q(result_q), .ovf_q(ovf_q)
);

// File: tb/test_fxmac_unit.sv
module test_fxmac_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  op;
    logic        as, bs, fr, sat;
    logic [31:0] a, b;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{req:2,  op:2'b01, as:1, bs:1, fr:0, sat:0, a:32'hFFFF_FFFD, b:32'd7},        // R2 -3*7
    '{req:6,  op:2'b10, as:1, bs:1, fr:0, sat:0, a:32'd5,         b:32'd4},        // R6 add
    '{req:7,  op:2'b11, as:1, bs:1, fr:0, sat:0, a:32'd2,         b:32'd3},        // R7 sub
    '{req:3,  op:2'b01, as:0, bs:0, fr:0, sat:0, a:32'hFFFF_FFFF, b:32'hFFFF_FFFF},// R3 max unsigned
    '{req:11, op:2'b01, as:0, bs:0, fr:0, sat:1, a:32'hFFFF_FFFF, b:32'hFFFF_FFFF},// R11 clamp pos
    '{req:4,  op:2'b01, as:1, bs:0, fr:0, sat:0, a:32'hFFFF_FFFF, b:32'hFFFF_FFFF},// R4 s*u
    '{req:4,  op:2'b01, as:0, bs:1, fr:0, sat:0, a:32'd2,         b:32'h8000_0000},// R4 u*s
    '{req:5,  op:2'b01, as:1, bs:1, fr:1, sat:0, a:32'h4000_0000, b:32'h4000_0000},// R5 0.5*0.5
    '{req:5,  op:2'b01, as:1, bs:1, fr:1, sat:1, a:32'h8000_0000, b:32'h8000_0000},// R5 -1*-1
    '{req:5,  op:2'b01, as:0, bs:1, fr:1, sat:0, a:32'h4000_0000, b:32'h4000_0000},// R5 no doubling
    '{req:11, op:2'b11, as:0, bs:0, fr:0, sat:1, a:32'hFFFF_FFFF, b:32'hFFFF_FFFF},// R11 clamp neg
    '{req:8,  op:2'b00, as:1, bs:1, fr:0, sat:0, a:32'h1234_5678, b:32'h9ABC_DEF0},// R8 clear
    '{req:12, op:2'b10, as:1, bs:1, fr:0, sat:1, a:32'h7FFF_FFFF, b:32'h7FFF_FFFF},// R12 chain
    '{req:12, op:2'b10, as:1, bs:1, fr:0, sat:1, a:32'h7FFF_FFFF, b:32'h7FFF_FFFF},// R12 chain
    '{req:6,  op:2'b10, as:0, bs:0, fr:0, sat:0, a:32'hFFFF_FFFF, b:32'hFFFF_FFFF} // R6 into guard
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic        a_signed = 1'b0, b_signed = 1'b0, frac_mode = 1'b0, rd_sat = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [79:0] acc_q;
  logic [63:0] result_q;
  logic        ovf_q;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [79:0] macc = '0;

  fxmac_unit i_fxmac_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .a_signed(a_signed), .b_signed(b_signed), .frac_mode(frac_mode),
    .op_a(op_a), .op_b(op_b), .rd_sat(rd_sat),
    .acc_q(acc_q), .result_q(result_q), .ovf_q(ovf_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [79:0] model_prod(logic [31:0] a, logic [31:0] b,
                                             logic as, logic bs, logic fr);
    logic signed [127:0] va, vb, p;
    va = as ? {{96{a[31]}}, a} : {96'd0, a};
    vb = bs ? {{96{b[31]}}, b} : {96'd0, b};
    p  = va * vb;
    if (fr && as && bs) p = p * 2;
    return p[79:0];
  endfunction

  function automatic logic model_ovf(logic [79:0] acc);
    return !(acc[79:63] == '0 || acc[79:63] == '1);
  endfunction

  function automatic logic [63:0] model_res(logic [79:0] acc, logic sat);
    if (sat && model_ovf(acc)) return acc[79] ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
    return acc[63:0];
  endfunction

  task automatic check(string tag, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag, logic sat);
    check({tag, " acc"}, acc_q, macc);
    check({tag, " result"}, {16'd0, result_q}, {16'd0, model_res(macc, sat)});
    check({tag, " ovf"}, {79'd0, ovf_q}, {79'd0, model_ovf(macc)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*4000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check_all("R1 reset", 1'b0);
    rst = 1'b0;

    // table walk, one operation per cycle (R12)
    for (int i = 0; i < NV; i++) begin
      op_valid  = 1'b1;
      op_code   = VEC[i].op;
      a_signed  = VEC[i].as;
      b_signed  = VEC[i].bs;
      frac_mode = VEC[i].fr;
      rd_sat    = VEC[i].sat;
      op_a      = VEC[i].a;
      op_b      = VEC[i].b;
      case (VEC[i].op)
        2'b00: macc = '0;
        2'b01: macc = model_prod(op_a, op_b, a_signed, b_signed, frac_mode);
        2'b10: macc = macc + model_prod(op_a, op_b, a_signed, b_signed, frac_mode);
        default: macc = macc - model_prod(op_a, op_b, a_signed, b_signed, frac_mode);
      endcase
      @(negedge clk);
      check_all($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].sat);
    end

    // R9: idle with changing operands, read-out select toggled
    op_valid = 1'b0; op_code = 2'b00; op_a = 32'hDEAD_BEEF; rd_sat = 1'b1;
    @(negedge clk);
    check_all("R9 idle sat", 1'b1);
    rd_sat = 1'b0; op_code = 2'b01;
    @(negedge clk);
    check_all("R9 idle full R10", 1'b0);

    // R10 full-width read of a small negative value
    op_valid = 1'b1; op_code = 2'b01; a_signed = 1'b1; b_signed = 1'b1;
    frac_mode = 1'b0; op_a = 32'hFFFF_FFFF; op_b = 32'd1; rd_sat = 1'b0;
    macc = {80{1'b1}};
    @(negedge clk);
    check_all("R10 minus one", 1'b0);

    // R1 reset in the middle of an operation stream
    op_code = 2'b10; rst = 1'b1; macc = '0;
    @(negedge clk);
    check_all("R1 mid-run reset", 1'b0);
    rst = 1'b0; op_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule